// File: doc/BRIEF.md
# Command-Prefix Write Guard for a Byte-Wide EEPROM Port

This block sits between a byte-write bus and an EEPROM programming engine. It decides, write by write, which writes reach the array. It holds one mode flag, write protection, which is clear after reset. While protection is clear, ordinary writes pass straight through. While protection is set, a data write passes only when a three-write command prefix comes directly before it.

The same three-write prefix also sets protection. A longer six-write command sequence clears it. Command writes never reach the engine. This includes writes that only partly match a command sequence. A write that breaks a sequence returns the recogniser to idle. That write is then judged as an ordinary write under the current mode.

A forwarded write appears on the output one clock after it was presented, with the same address and data. The mode flag and the sequence-busy flag change on the clock edge that accepts the write.

Top module: `eeprot_guard`

## Requirements
- R1: After reset, the protection flag is 0, the busy flag is 0 and no write is forwarded.
- R2: With protection clear, a write that does not start or continue a command sequence is forwarded one cycle later with unchanged address and data.
- R3: A write of data AA to address 5555 from the idle step, and each further write that matches the next expected step, is not forwarded, and the busy flag is 1 after it.
- R4: A step that expects data 55 accepts address 2AAA or address AAAA. Any other address, such as 6AAA, breaks the sequence.
- R5: The prefix AA@5555, 55@2AAA/AAAA, A0@5555 sets protection. The very next write is forwarded whatever the mode, once only.
- R6: With protection set, a write not directly preceded by the prefix is not forwarded.
- R7: The sequence AA@5555, 55@2AAA/AAAA, 80@5555, AA@5555, 55@2AAA/AAAA, 20@5555 clears protection, and none of its six writes is forwarded.
- R8: A write that does not match the expected step clears the busy flag and is judged as an ordinary write under the current mode. It does not itself start a new sequence, even when it is AA@5555. Withheld command writes are discarded.
- R9: The prefix issued while protection is set leaves protection set and still lets the next write through.
- R10: The clearing sequence issued while protection is clear leaves it clear and forwards nothing.
- R11: Cycles without a write do not advance or reset the recogniser and forward nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A byte write is presented this cycle |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| fwdValid | output | 1 | Write allowed to the programming engine |
| fwdAddr | output | 16 | Address of the forwarded write |
| fwdData | output | 8 | Data of the forwarded write |
| protOn | output | 1 | Write protection active |
| seqBusy | output | 1 | A command sequence is partly received |

## Verification
Ordinary writes are swept over all 256 data values, once with protection clear and once with it set. Every one must pass in the first sweep and every one must be blocked in the second, so the two sweeps show that the mode alone decides ordinary traffic. Directed sequences then try the prefix and the clearing sequence from both modes, using both accepted forms of the 55-step address. These show that a mode change happens only on the final command byte, and that the write after the prefix is the only extra one let through. Broken sequences, with a wrong address, wrong data, a repeated AA@5555 or an abort at step four, show that the breaking write is judged by the current mode and that idle cycles in the middle leave the recogniser where it was.

// File: rtl/eeprot_pkg.sv
package eeprot_pkg;

  localparam logic [15:0] CMD_ADDR  = 16'h5555;
  localparam logic [15:0] ALT_ADDR0 = 16'h2AAA;
  localparam logic [15:0] ALT_ADDR1 = 16'hAAAA;
  localparam logic [7:0]  CODE_OPEN  = 8'hAA;
  localparam logic [7:0]  CODE_KEY   = 8'h55;
  localparam logic [7:0]  CODE_LOCK  = 8'hA0;
  localparam logic [7:0]  CODE_EXT   = 8'h80;
  localparam logic [7:0]  CODE_FREE  = 8'h20;

  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic fwd;
    logic setProt;
    logic clrProt;
  } ctrlStrb_t;

  // Decoded properties of the current write.
  typedef struct packed {
    logic cmdAddr;
    logic altAddr;
    logic isOpen;
    logic isKey;
    logic isLock;
    logic isExt;
    logic isFree;
  } matchFlags_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_G1    = 3'd1,
    ST_G2    = 3'd2,
    ST_G3    = 3'd3,
    ST_G4    = 3'd4,
    ST_G5    = 3'd5,
    ST_ARMED = 3'd6
  } seqState_t;

endpackage

// File: rtl/eeprot_datapath.sv
module eeprot_datapath
  import eeprot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrb_t         strb,
  output matchFlags_t       match,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              protOn
);

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(ALT_ADDR0);
  localparam logic [ADDR_W-1:0] ALT_B = ADDR_W'(ALT_ADDR1);

  always_comb begin
    match.cmdAddr = (wrAddr == CMD_A);
    match.altAddr = (wrAddr == ALT_A) || (wrAddr == ALT_B);
    match.isOpen  = (wrData == DATA_W'(CODE_OPEN));
    match.isKey   = (wrData == DATA_W'(CODE_KEY));
    match.isLock  = (wrData == DATA_W'(CODE_LOCK));
    match.isExt   = (wrData == DATA_W'(CODE_EXT));
    match.isFree  = (wrData == DATA_W'(CODE_FREE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      fwdData  <= '0;
      protOn   <= 1'b0;
    end else begin
      fwdValid <= strb.fwd;
      if (strb.fwd) begin
        fwdAddr <= wrAddr;
        fwdData <= wrData;
      end
      if (strb.setProt)      protOn <= 1'b1;
      else if (strb.clrProt) protOn <= 1'b0;
    end
  end

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fwd, strb.setProt, strb.clrProt})); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrProt |=> (!protOn && !fwdValid)); // R7
  AST_SET_PROT: assert property (@(posedge clk) disable iff (!rstN)
    strb.setProt |=> (protOn && !fwdValid)); // R5
  AST_FWD_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN)
    strb.fwd |-> wrValid); // R11

endmodule

// File: rtl/eeprot_control.sv
module eeprot_control
  import eeprot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  matchFlags_t match,
  input  logic        protOn,
  output ctrlStrb_t   strb,
  output logic        seqBusy
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    if (wrValid) begin
      unique case (state)
        ST_IDLE: begin
          if (match.cmdAddr && match.isOpen) nextState = ST_G1;
          else strb.fwd = !protOn;
        end
        ST_G1, ST_G4: begin
          if (match.altAddr && match.isKey) begin
            nextState = (state == ST_G1) ? ST_G2 : ST_G5;
          end else begin
            nextState = ST_IDLE;
            strb.fwd  = !protOn;
          end
        end
        ST_G2: begin
          if (match.cmdAddr && match.isLock) begin
            nextState    = ST_ARMED;
            strb.setProt = 1'b1;
          end else if (match.cmdAddr && match.isExt) begin
            nextState = ST_G3;
          end else begin
            nextState = ST_IDLE;
            strb.fwd  = !protOn;
          end
        end
        ST_G3: begin
          if (match.cmdAddr && match.isOpen) nextState = ST_G4;
          else begin
            nextState = ST_IDLE;
            strb.fwd  = !protOn;
          end
        end
        ST_G5: begin
          nextState = ST_IDLE;
          if (match.cmdAddr && match.isFree) strb.clrProt = 1'b1;
          else strb.fwd = !protOn;
        end
        ST_ARMED: begin
          nextState = ST_IDLE;
          strb.fwd  = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign seqBusy = (state != ST_IDLE) && (state != ST_ARMED);

  AST_ARMED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && wrValid) |-> strb.fwd); // R5
  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && state != ST_ARMED && wrValid) |-> !strb.fwd); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(state)); // R11
  AST_BUSY_SWALLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && nextState != ST_IDLE && nextState != ST_ARMED) |-> !strb.fwd); // R3

endmodule

// File: rtl/eeprot_guard.sv
module eeprot_guard
  import eeprot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              protOn,
  output logic              seqBusy
);

  ctrlStrb_t   strb;
  matchFlags_t match;

  eeprot_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .match(match), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdData(fwdData), .protOn(protOn)
  );

  eeprot_control u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .match(match),
    .protOn(protOn), .strb(strb), .seqBusy(seqBusy)
  );

endmodule

// File: tb/eeprot_guard_tb.sv
module eeprot_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        fwdValid, protOn, seqBusy;
  logic [15:0] fwdAddr;
  logic [7:0]  fwdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eeprot_guard u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .fwdData(fwdData),
    .protOn(protOn), .seqBusy(seqBusy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Present one write (or an idle cycle), then sample after the capturing edge.
  task automatic step(input bit v, input logic [15:0] a, input logic [7:0] d,
                      input bit expF, input bit expP, input bit expB, input string tag);
    wrValid = v;
    wrAddr  = a;
    wrData  = d;
    @(negedge clk);
    chk(tag, "fwdValid", fwdValid, expF);
    if (expF) begin
      chk(tag, "fwdAddr", fwdAddr, a);
      chk(tag, "fwdData", fwdData, d);
    end
    chk(tag, "protOn", protOn, expP);
    chk(tag, "seqBusy", seqBusy, expB);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "fwdValid", fwdValid, 0);
    chk("R1", "protOn", protOn, 0);
    chk("R1", "seqBusy", seqBusy, 0);
    step(0, 16'h5555, 8'hAA, 0, 0, 0, "R11");

    // Unprotected sweep: every ordinary write passes.
    for (int d = 0; d < 256; d++)
      step(1, 16'(d * 256 + 3), 8'(d), 1, 0, 0, "R2");

    // Partial match then break by an unrelated write.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R3");
    step(1, 16'hAAAA, 8'h55, 0, 0, 1, "R4");
    step(1, 16'h0100, 8'h12, 1, 0, 0, "R8");
    // Idle cycle mid-sequence, then a rejected 55-step address.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R3");
    step(0, 16'h0000, 8'h00, 0, 0, 1, "R11");
    step(1, 16'h6AAA, 8'h55, 1, 0, 0, "R4");

    // Prefix while unprotected.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R5");
    step(1, 16'h2AAA, 8'h55, 0, 0, 1, "R5");
    step(1, 16'h5555, 8'hA0, 0, 1, 0, "R5");
    step(1, 16'h1234, 8'h3C, 1, 1, 0, "R5");
    step(1, 16'h1235, 8'h3D, 0, 1, 0, "R6");

    // Protected sweep: every ordinary write blocked.
    for (int d = 0; d < 256; d++)
      step(1, 16'(d * 256 + 7), 8'(d), 0, 1, 0, "R6");

    // Broken prefix while protected.
    step(1, 16'h5555, 8'hAA, 0, 1, 1, "R8");
    step(1, 16'h2AAA, 8'h55, 0, 1, 1, "R8");
    step(1, 16'h5555, 8'h77, 0, 1, 0, "R8");
    step(1, 16'h5555, 8'hAA, 0, 1, 1, "R8");
    step(1, 16'h5555, 8'hAA, 0, 1, 0, "R8");

    // Prefix while protected.
    step(1, 16'h5555, 8'hAA, 0, 1, 1, "R9");
    step(1, 16'hAAAA, 8'h55, 0, 1, 1, "R9");
    step(1, 16'h5555, 8'hA0, 0, 1, 0, "R9");
    step(1, 16'h0042, 8'h99, 1, 1, 0, "R9");
    step(1, 16'h0043, 8'h98, 0, 1, 0, "R9");

    // Clearing sequence.
    step(1, 16'h5555, 8'hAA, 0, 1, 1, "R7");
    step(1, 16'hAAAA, 8'h55, 0, 1, 1, "R7");
    step(1, 16'h5555, 8'h80, 0, 1, 1, "R7");
    step(1, 16'h5555, 8'hAA, 0, 1, 1, "R7");
    step(1, 16'h2AAA, 8'h55, 0, 1, 1, "R7");
    step(1, 16'h5555, 8'h20, 0, 0, 0, "R7");
    step(1, 16'h0010, 8'h5A, 1, 0, 0, "R2");

    // Clearing sequence while already unprotected.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R10");
    step(1, 16'h2AAA, 8'h55, 0, 0, 1, "R10");
    step(1, 16'h5555, 8'h80, 0, 0, 1, "R10");
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R10");
    step(1, 16'hAAAA, 8'h55, 0, 0, 1, "R10");
    step(1, 16'h5555, 8'h20, 0, 0, 0, "R10");

    // Repeated opener breaks and is forwarded as ordinary data.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R8");
    step(1, 16'h5555, 8'hAA, 1, 0, 0, "R8");
    // Abort at step four of the clearing sequence.
    step(1, 16'h5555, 8'hAA, 0, 0, 1, "R8");
    step(1, 16'h2AAA, 8'h55, 0, 0, 1, "R8");
    step(1, 16'h5555, 8'h80, 0, 0, 1, "R8");
    step(1, 16'h0300, 8'h01, 1, 0, 0, "R8");
    step(0, 16'h0000, 8'h00, 0, 0, 0, "R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule